// File: doc/BRIEF.md
# Read-Strobe Delay Window Search Engine

This engine finds the edges of the passing read-strobe delay window for two byte lanes of a memory interface. Each lane's delay has two levels: a coarse tap and a fine tap. For every candidate setting the engine drives a 16-bit tap word, pulses a test request to an external pattern tester and waits for its pass/fail answer. It then steps the setting up or down as described below. The engine searches lane 0 to completion and then lane 1. Within a lane it finds the upper edge first (coarse, then fine) and then the lower edge (coarse, then fine).

The lower edge search is limited by bounds. These bounds come from the coarse and fine readings of a delay-locked loop. The engine captures both readings when a run is started. The fine searches carry into, or borrow from, the coarse result when the fine sweep falls off its range. At the end, each lane reports four nibbles: highest coarse, highest fine, lowest coarse and lowest fine. A separate stage outside this block uses them to centre the strobe.

Top module: `dqs_window_search`

## Requirements
- R1: The tap word carries the lane under test as an 8-bit {coarse, fine} byte. Lane 0 uses bits [7:4] for coarse and [3:0] for fine. Lane 1 uses bits [15:12] for coarse and [11:8] for fine. The byte of the other lane reads 0x74. While idle the word is 0x7474. The word does not change while the engine waits for a test answer.
- R2: Upper coarse search. The first probe is coarse 7 with fine 15. A pass raises coarse by one; a fail ends the search. The value reached is stored as the highest coarse. That value is the first failing value, or 16 if every value up to 15 passed; 16 is reported as 0.
- R3: Upper fine search. Coarse is set to the highest coarse and fine starts at 0. A pass raises fine by one; a fail or reaching 15 ends the search. The highest fine is the last passing value. If the first probe fails, the highest coarse drops by one and the highest fine becomes 15.
- R4: Lower coarse search. The first probe is coarse 6 with fine 0. A pass lowers coarse by one. The search stops on a fail, when the probed value equals the coarse bound, or when the lowered value falls below that bound. The value held at the stop is the lowest coarse.
- R5: Lower fine search. Coarse is set to the lowest coarse and fine starts at 15. A pass lowers fine by one. A fail raises the value by one and stops. The search also stops at the fine bound, or below it. If the result is 16, the lowest coarse rises by one and the lowest fine becomes 0.
- R6: Each bound is 8 minus the matching loop reading when that reading is at most 8, and 0 otherwise.
- R7: Lane 0 runs all four searches, in the order upper coarse, upper fine, lower coarse, lower fine, before lane 1 runs the same four.
- R8: Each test request is a single-cycle pulse. No new request is issued until the tester raises done. The pass input is sampled in the done cycle.
- R9: busy_o is high from the cycle after an accepted start until the run ends. done_o pulses for one cycle as busy_o falls. A start is ignored while busy. A start in the done_o cycle begins a new run.
- R10: After reset the engine is idle: no request, busy_o low, done_o low, and all results 0.
- R11: The engine captures the loop readings in the cycle the start is accepted. Later changes to those inputs do not affect the run.
- R12: Each result port holds lane 1 in bits [7:4] and lane 0 in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a calibration run |
| dll_coarse_i | input | 4 | Coarse reading of the delay-locked loop |
| dll_fine_i | input | 4 | Fine reading of the delay-locked loop |
| test_req_o | output | 1 | One-cycle request to run a pattern test |
| tap_word_o | output | 16 | Delay tap word for the current probe |
| test_done_i | input | 1 | Tester finished; pass valid |
| test_pass_i | input | 1 | Tester result |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle run-complete pulse |
| hi_coarse_o | output | 8 | Highest coarse per lane |
| hi_fine_o | output | 8 | Highest fine per lane |
| lo_coarse_o | output | 8 | Lowest coarse per lane |
| lo_fine_o | output | 8 | Lowest fine per lane |

## Verification
A fine-search step and its carry or borrow into the stored coarse result can fall in the same decision cycle. This happens when the upper fine sweep fails on its first probe, and when the lower fine sweep fails at 15. The bench builds tester windows that force both cases on different lanes and runs. It judges them by the reported nibbles and by the exact coarse value seen in the probe sequence. A new start can also coincide with the completion pulse. The bench raises start in the done_o cycle, then checks that the old results are reported intact and that the new probe sequence follows with no gap.

// File: rtl/dqs_win_pkg.sv
package dqs_win_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} state_e;
  typedef enum logic [1:0] {PH_HI_C, PH_HI_F, PH_LO_C, PH_LO_F} phase_e;
endpackage

// File: rtl/dqs_lower_bound.sv
module dqs_lower_bound #(
  parameter int TAP_W = 4
) (
  input  logic [TAP_W-1:0] rd_i,
  output logic [TAP_W-1:0] bnd_o
);
  localparam logic [TAP_W-1:0] REF = TAP_W'(1 << (TAP_W - 1));

  always_comb begin
    if (rd_i <= REF) bnd_o = REF - rd_i;
    else             bnd_o = '0;
  end
endmodule

// File: rtl/dqs_tap_pack.sv
module dqs_tap_pack #(
  parameter int                   TAP_W     = 4,
  parameter logic [2*TAP_W-1:0]   IDLE_BYTE = 8'h74
) (
  input  logic               active_i,
  input  logic               lane_i,
  input  logic [TAP_W-1:0]   coarse_i,
  input  logic [TAP_W-1:0]   fine_i,
  output logic [4*TAP_W-1:0] word_o
);
  logic [2*TAP_W-1:0] probe_byte;
  assign probe_byte = {coarse_i, fine_i};

  always_comb begin
    if (!active_i)   word_o = {IDLE_BYTE, IDLE_BYTE};
    else if (lane_i) word_o = {probe_byte, IDLE_BYTE};
    else             word_o = {IDLE_BYTE, probe_byte};
  end
endmodule

// File: rtl/dqs_window_search.sv
module dqs_window_search
  import dqs_win_pkg::*;
#(
  parameter int                 TAP_W      = 4,
  parameter int                 HI_C_START = 7,
  parameter int                 LO_C_START = 6,
  parameter logic [2*TAP_W-1:0] IDLE_BYTE  = 8'h74
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [TAP_W-1:0]   dll_coarse_i,
  input  logic [TAP_W-1:0]   dll_fine_i,
  output logic               test_req_o,
  output logic [4*TAP_W-1:0] tap_word_o,
  input  logic               test_done_i,
  input  logic               test_pass_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*TAP_W-1:0] hi_coarse_o,
  output logic [2*TAP_W-1:0] hi_fine_o,
  output logic [2*TAP_W-1:0] lo_coarse_o,
  output logic [2*TAP_W-1:0] lo_fine_o
);
  localparam int            CW    = TAP_W + 1;
  localparam int            LANES = 2;
  localparam logic [CW-1:0] T_MAX = CW'((1 << TAP_W) - 1);
  localparam logic [CW-1:0] T_OVF = CW'(1 << TAP_W);
  localparam logic [CW-1:0] T_HC0 = CW'(HI_C_START);
  localparam logic [CW-1:0] T_LC0 = CW'(LO_C_START);

  state_e             st_q;
  phase_e             ph_q;
  logic               lane_q;
  logic               done_q;
  logic [CW-1:0]      t_q;
  logic [TAP_W-1:0]   dllc_q, dllf_q;
  logic [CW-1:0]      hic_q [LANES];
  logic [CW-1:0]      loc_q [LANES];
  logic [TAP_W-1:0]   hif_q [LANES];
  logic [TAP_W-1:0]   lof_q [LANES];

  // bounds from captured loop readings
  logic [TAP_W-1:0] bnd_c, bnd_f;
  dqs_lower_bound #(.TAP_W(TAP_W)) u_bnd_c (.rd_i(dllc_q), .bnd_o(bnd_c));
  dqs_lower_bound #(.TAP_W(TAP_W)) u_bnd_f (.rd_i(dllf_q), .bnd_o(bnd_f));
  logic [CW-1:0] bc_x, bf_x;
  assign bc_x = {1'b0, bnd_c};
  assign bf_x = {1'b0, bnd_f};

  // probe setting
  logic [TAP_W-1:0] cur_c, cur_f;
  always_comb begin
    case (ph_q)
      PH_HI_C: begin cur_c = t_q[TAP_W-1:0];             cur_f = T_MAX[TAP_W-1:0]; end
      PH_HI_F: begin cur_c = hic_q[lane_q][TAP_W-1:0];   cur_f = t_q[TAP_W-1:0];   end
      PH_LO_C: begin cur_c = t_q[TAP_W-1:0];             cur_f = '0;               end
      default: begin cur_c = loc_q[lane_q][TAP_W-1:0];   cur_f = t_q[TAP_W-1:0];   end
    endcase
  end

  dqs_tap_pack #(.TAP_W(TAP_W), .IDLE_BYTE(IDLE_BYTE)) u_pack (
    .active_i (st_q != ST_IDLE),
    .lane_i   (lane_q),
    .coarse_i (cur_c),
    .fine_i   (cur_f),
    .word_o   (tap_word_o)
  );

  // step decision on a tester answer
  logic [CW-1:0] t_inc, t_dec, t_next;
  logic          ph_end;
  assign t_inc = t_q + CW'(1);
  assign t_dec = t_q - CW'(1);

  always_comb begin
    ph_end = 1'b0;
    t_next = t_q;
    case (ph_q)
      PH_HI_C: begin
        if (!test_pass_i) ph_end = 1'b1;
        else begin t_next = t_inc; ph_end = (t_q == T_MAX); end
      end
      PH_HI_F: begin
        if (!test_pass_i || t_q == T_MAX) ph_end = 1'b1;
        else t_next = t_inc;
      end
      PH_LO_C: begin
        if (!test_pass_i || t_q == bc_x) ph_end = 1'b1;
        else begin t_next = t_dec; ph_end = (t_dec < bc_x); end
      end
      default: begin
        if (!test_pass_i) begin t_next = t_inc; ph_end = 1'b1; end
        else if (t_q == bf_x) ph_end = 1'b1;
        else begin t_next = t_dec; ph_end = (t_dec < bf_x); end
      end
    endcase
  end

  logic [CW-1:0] hf_store;
  logic          hf_wrap;
  assign hf_store = test_pass_i ? t_q : t_dec;
  assign hf_wrap  = !test_pass_i && (t_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_HI_C;
      lane_q <= 1'b0;
      done_q <= 1'b0;
      t_q    <= '0;
      dllc_q <= '0;
      dllf_q <= '0;
      for (int l = 0; l < LANES; l++) begin
        hic_q[l] <= '0;
        loc_q[l] <= '0;
        hif_q[l] <= '0;
        lof_q[l] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_ISSUE;
          ph_q   <= PH_HI_C;
          lane_q <= 1'b0;
          t_q    <= T_HC0;
          dllc_q <= dll_coarse_i;
          dllf_q <= dll_fine_i;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        default: if (test_done_i) begin
          st_q <= ST_ISSUE;
          if (!ph_end) t_q <= t_next;
          else begin
            case (ph_q)
              PH_HI_C: begin
                hic_q[lane_q] <= t_next;
                ph_q <= PH_HI_F;
                t_q  <= '0;
              end
              PH_HI_F: begin
                if (hf_wrap) begin
                  hic_q[lane_q] <= hic_q[lane_q] - CW'(1);
                  hif_q[lane_q] <= T_MAX[TAP_W-1:0];
                end else hif_q[lane_q] <= hf_store[TAP_W-1:0];
                ph_q <= PH_LO_C;
                t_q  <= T_LC0;
              end
              PH_LO_C: begin
                loc_q[lane_q] <= t_next;
                ph_q <= PH_LO_F;
                t_q  <= T_MAX;
              end
              default: begin
                if (t_next == T_OVF) begin
                  loc_q[lane_q] <= loc_q[lane_q] + CW'(1);
                  lof_q[lane_q] <= '0;
                end else lof_q[lane_q] <= t_next[TAP_W-1:0];
                ph_q <= PH_HI_C;
                if (lane_q) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                  lane_q <= 1'b0;
                end else begin
                  lane_q <= 1'b1;
                  t_q    <= T_HC0;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  assign test_req_o = (st_q == ST_ISSUE);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;

  for (genvar l = 0; l < LANES; l++) begin : g_res
    assign hi_coarse_o[l*TAP_W +: TAP_W] = hic_q[l][TAP_W-1:0];
    assign hi_fine_o  [l*TAP_W +: TAP_W] = hif_q[l];
    assign lo_coarse_o[l*TAP_W +: TAP_W] = loc_q[l][TAP_W-1:0];
    assign lo_fine_o  [l*TAP_W +: TAP_W] = lof_q[l];
  end

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_req_o |=> !test_req_o); // R8
  AST_TAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !test_done_i) |=> $stable(tap_word_o)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_LANE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lane_q) |-> done_o); // R7
  AST_FINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ph_q == PH_LO_F) |-> (t_q <= T_MAX)); // R5
endmodule

// File: tb/dqs_window_search_tb.sv
`timescale 1ns/1ps
module dqs_window_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  dllc = '0, dllf = '0;
  logic        req;
  logic [15:0] tap;
  logic        tdone = 1'b0, tpass = 1'b0;
  logic        busy, done;
  logic [7:0]  hc, hf, lc, lf;

  always #2.5 clk = ~clk;

  dqs_window_search u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dll_coarse_i(dllc), .dll_fine_i(dllf),
    .test_req_o(req), .tap_word_o(tap),
    .test_done_i(tdone), .test_pass_i(tpass),
    .busy_o(busy), .done_o(done),
    .hi_coarse_o(hc), .hi_fine_o(hf), .lo_coarse_o(lc), .lo_fine_o(lf)
  );

  int n_chk = 0, n_bad = 0;
  int win_lo[2], win_hi[2];
  int lat_sel = 1;

  logic [16:0] tap_q[$];   // {lane, word}
  logic [31:0] res_q[$];   // {hc, hf, lc, lf}

  function automatic void chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endfunction

  // R1: expected word for a probe; pass window is in units of coarse*8+fine
  function automatic bit probe(int l, int c, int f);
    logic [7:0]  pb;
    logic [15:0] w;
    int          d;
    pb = {c[3:0], f[3:0]};
    w  = l ? {pb, 8'h74} : {8'h74, pb};
    tap_q.push_back({l[0], w});
    d = int'(c[3:0]) * 8 + int'(f[3:0]);
    return (d >= win_lo[l]) && (d <= win_hi[l]);
  endfunction

  // expected probe sequence and results (R2..R7, R12)
  function automatic void ref_run(logic [3:0] dc, logic [3:0] df);
    int bc, bf, t;
    int mc[2], mf[2], nc[2], nf[2];
    bc = (dc <= 8) ? 8 - int'(dc) : 0;   // R6
    bf = (df <= 8) ? 8 - int'(df) : 0;
    for (int l = 0; l < 2; l++) begin
      t = 7;                              // R2
      while (1) begin
        if (!probe(l, t, 15)) begin mc[l] = t; break; end
        t++;
        if (t > 15) begin mc[l] = t; break; end
      end
      t = 0;                              // R3
      while (1) begin
        if (!probe(l, mc[l], t)) begin
          if (t == 0) begin mc[l]--; mf[l] = 15; end else mf[l] = t - 1;
          break;
        end
        if (t == 15) begin mf[l] = 15; break; end
        t++;
      end
      t = 6;                              // R4
      while (1) begin
        if (!probe(l, t, 0) || t == bc) begin nc[l] = t; break; end
        t--;
        if (t < bc) begin nc[l] = t; break; end
      end
      t = 15;                             // R5
      while (1) begin
        if (!probe(l, nc[l], t)) begin
          t++;
          if (t == 16) begin nc[l]++; nf[l] = 0; end else nf[l] = t;
          break;
        end
        if (t == bf) begin nf[l] = t; break; end
        t--;
        if (t < bf) begin nf[l] = t; break; end
      end
    end
    res_q.push_back({mc[1][3:0], mc[0][3:0], mf[1][3:0], mf[0][3:0],
                     nc[1][3:0], nc[0][3:0], nf[1][3:0], nf[0][3:0]});
  endfunction

  // tester model: checks each request against the expected probe
  int          nreq = 0;
  bit          pend = 0;
  int          cnt = 0;
  bit          res_pass = 0;
  bit          req_prev = 0;
  initial begin
    forever begin
      @(negedge clk);
      tdone = 1'b0;
      if (pend) begin
        if (cnt == 0) begin tdone = 1'b1; tpass = res_pass; pend = 0; end
        else cnt--;
      end
      if (req) begin
        logic [16:0] e;
        int d;
        chk(!req_prev, "R8 request wider than one cycle", 32'(req_prev), 32'(0));
        chk(!pend, "R8 request before done", 32'(pend), 32'(0));
        if (tap_q.size() == 0) begin
          chk(0, "R7 unexpected probe", 32'(tap), 32'(0));
          res_pass = 0;
        end else begin
          e = tap_q.pop_front();
          chk(tap == e[15:0], "R1 R7 probe tap word", 32'(tap), 32'(e[15:0]));
          d = e[16] ? int'(tap[15:12]) * 8 + int'(tap[11:8])
                    : int'(tap[7:4]) * 8 + int'(tap[3:0]);
          res_pass = (d >= win_lo[e[16]]) && (d <= win_hi[e[16]]);
        end
        pend = 1;
        cnt  = (nreq * lat_sel) % 5;
        nreq++;
      end
      req_prev = req;
    end
  end

  // monitor: compare results on completion
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (res_q.size() == 0) chk(0, "R9 unexpected done", 32'(1), 32'(0));
        else begin
          logic [31:0] e;
          e = res_q.pop_front();
          chk(hc == e[31:24], "R2 R3 R12 hi coarse", 32'(hc), 32'(e[31:24]));
          chk(hf == e[23:16], "R3 hi fine", 32'(hf), 32'(e[23:16]));
          chk(lc == e[15:8],  "R4 R5 lo coarse", 32'(lc), 32'(e[15:8]));
          chk(lf == e[7:0],   "R5 R6 lo fine", 32'(lf), 32'(e[7:0]));
        end
      end
    end
  end

  task automatic set_win(int l0, int h0, int l1, int h1);
    win_lo[0] = l0; win_hi[0] = h0; win_lo[1] = l1; win_hi[1] = h1;
  endtask

  task automatic kick(logic [3:0] dc, logic [3:0] df);
    dllc = dc; dllf = df;
    ref_run(dc, df);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", 32'(busy), 32'(1));
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic finish_run();
    wait_done();
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R9 idle after done", {30'd0, busy, done}, 32'(0));
    chk(tap == 16'h7474, "R1 idle tap word", 32'(tap), 32'h7474);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 32'(0), 32'(1));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({req, busy, done} == 3'b000, "R10 outputs in reset", 32'({req, busy, done}), 32'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({req, busy, done} == 3'b000, "R10 idle after reset", 32'({req, busy, done}), 32'(0));
    chk({hc, hf, lc, lf} == 32'd0, "R10 results after reset", {hc, hf, lc, lf}, 32'(0));
    chk(tap == 16'h7474, "R1 R10 tap word after reset", 32'(tap), 32'h7474);

    // A: ordinary windows, bounds 5/6
    lat_sel = 1;
    set_win(30, 80, 20, 70);
    kick(4'd3, 4'd2);
    finish_run();

    // B: lane 0 upper fine wrap, lane 1 lower fine carry, bounds 0 (R6 reading > 8)
    lat_sel = 2;
    set_win(40, 55, 64, 120);
    kick(4'd10, 4'd9);
    finish_run();

    // C: lane 0 all pass (coarse reaches 16), lane 1 narrow window, bounds 0 at reading 8
    lat_sel = 0;
    set_win(0, 200, 60, 62);
    kick(4'd8, 4'd8);
    // R9: start while busy is ignored; R11: loop readings change mid-run
    repeat (6) @(negedge clk);
    start = 1'b1; dllc = 4'd0; dllf = 4'd0;
    @(negedge clk); start = 1'b0;
    finish_run();

    // D: coarse bound 7 above the lower start, fine bound 8
    lat_sel = 3;
    set_win(0, 100, 10, 90);
    kick(4'd1, 4'd0);
    wait_done();
    // E: restart in the done cycle
    set_win(45, 130, 0, 47);
    dllc = 4'd6; dllf = 4'd12;
    ref_run(4'd6, 4'd12);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R9 start in done cycle accepted", 32'(busy), 32'(1));
    dllc = 4'd15; dllf = 4'd15;   // R11
    finish_run();

    repeat (10) @(negedge clk);
    chk(tap_q.size() == 0, "R7 all probes issued", 32'(tap_q.size()), 32'(0));
    chk(res_q.size() == 0, "R9 all runs completed", 32'(res_q.size()), 32'(0));
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule